// File: doc/BRIEF.md
# Sleep Mode Entry and Recovery Controller

This controller sits between the power-down request pin of a synchronous burst memory and the cycle controller that accepts address strobes. The request arrives asynchronously. It is resynchronised to the memory clock. A small state machine then times a fixed entry window before the memory counts as asleep. When the request is dropped, it times a fixed recovery window before normal operation resumes.

Outside normal operation, the controller blocks both address strobes (the processor-side strobe and the controller-side strobe). It also withholds output drive, so the data pins stay at high impedance whatever the output-enable request says. A strobe that arrives while it is blocked is dropped. The same cycle raises a violation pulse that a bench or monitor can count. The memory array is not touched, so its contents are kept for as long as the clock keeps running.

The cycle controller receives three things from this block: the state code, a strobe-permit level, and the gated strobes themselves.

Top module: `slp_ctrl`

## Requirements
- R1: After reset, `sleep_state` is 0 (normal), `strobe_permit` is 1 and `strobe_err` is 0. State codes are: 0 normal, 1 entering, 2 sleeping, 3 recovering.
- R2: `sleep_req` passes through a two-flop synchroniser. A request that is first seen at clock edge 1 moves the state to entering after edge 3.
- R3: The state stays in entering for exactly 2 cycles. If the request is still present, the state is sleeping after the second of those cycles, and `asleep` is 1 exactly while the state is sleeping.
- R4: If the synchronised request drops while entering or sleeping, the state goes to recovering at the next edge. For a request held for W edges (W at least 1), recovering begins after edge W+3. This includes the case where the request is dropped during the entry window.
- R5: Recovering lasts exactly 2 cycles and is then followed by normal. Over the whole sweep, the state after edge n is therefore: normal for n<3; entering for 3≤n≤4 with n<W+3; sleeping for 5≤n<W+3; recovering for W+3≤n<W+5; and normal afterwards.
- R6: `strobe_p_ok` equals `strobe_p` and `strobe_c_ok` equals `strobe_c` only in state normal. In every other state both are 0, so both strobes are ignored.
- R7: `strobe_err` is 1 in a cycle exactly when either strobe is high and the state is not normal.
- R8: `data_drive_en` equals `oe_req` in state normal and is 0 in all other states, so the outputs are high impedance during entry, sleep and recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | Asynchronous power-down request, high asserts |
| oe_req | input | 1 | Output-enable request from the data path |
| strobe_p | input | 1 | Processor-side address strobe |
| strobe_c | input | 1 | Controller-side address strobe |
| sleep_state | output | 2 | State code (0 normal, 1 entering, 2 sleeping, 3 recovering) |
| asleep | output | 1 | High while in the sleeping state |
| strobe_permit | output | 1 | High when address strobes may be accepted |
| strobe_p_ok | output | 1 | Processor strobe after gating |
| strobe_c_ok | output | 1 | Controller strobe after gating |
| data_drive_en | output | 1 | Enable for the data output drivers |
| strobe_err | output | 1 | Pulse for a strobe that was presented while blocked |

## Verification
Two functions can meet in one cycle: the timed return from recovery to normal, and an incoming strobe. The last recovering cycle must still reject the strobe and flag it. The very next cycle must accept it with no flag. The bench sweeps the request width W from 1 to 8 edges. In every cycle of every sweep it drives a strobe pattern and an output-enable pattern that both change with the cycle number, so each boundary cycle sees each strobe combination. The expected state, gating, drive enable and violation flag are derived from W and the cycle number by the closed-form rule in R5.

// File: rtl/slp_pkg.sv
package slp_pkg;

  typedef enum logic [1:0] {
    ST_NORMAL  = 2'd0,
    ST_ENTER   = 2'd1,
    ST_SLEEP   = 2'd2,
    ST_RECOVER = 2'd3
  } slp_state_e;

  // larger of two window lengths
  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // bits needed to hold a down-counter starting at len-1
  function automatic int cnt_width(input int len);
    return (len <= 2) ? 1 : $clog2(len);
  endfunction

  // strobes may be accepted only in normal operation
  function automatic logic permits(input slp_state_e s);
    return s == ST_NORMAL;
  endfunction

endpackage

// File: rtl/slp_sync.sv
module slp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];

  // R2: the output only follows a value the first flop held a cycle earlier
  sync_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_out != $past(sync_out)) |-> (sync_out == $past(chain_q[STAGES-2])));
endmodule

// File: rtl/slp_fsm.sv
module slp_fsm
  import slp_pkg::*;
#(
  parameter int ENTRY_CYC = 2,
  parameter int RECOV_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_sync,
  output slp_state_e state,
  output logic       window_done
);
  localparam int CW = cnt_width(max_of(ENTRY_CYC, RECOV_CYC));
  localparam logic [CW-1:0] ENTRY_LOAD = CW'(ENTRY_CYC - 1);
  localparam logic [CW-1:0] RECOV_LOAD = CW'(RECOV_CYC - 1);

  slp_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign window_done = (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_NORMAL: if (req_sync) begin
        state_d = ST_ENTER;
        cnt_d   = ENTRY_LOAD;
      end
      ST_ENTER: begin
        if (!req_sync) begin
          state_d = ST_RECOVER;
          cnt_d   = RECOV_LOAD;
        end else if (window_done) begin
          state_d = ST_SLEEP;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_SLEEP: if (!req_sync) begin
        state_d = ST_RECOVER;
        cnt_d   = RECOV_LOAD;
      end
      ST_RECOVER: begin
        if (window_done) state_d = ST_NORMAL;
        else             cnt_d   = cnt_q - 1'b1;
      end
      default: state_d = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_NORMAL;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state = state_q;

  // R3: sleep is reached only through the entry window
  sleep_via_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP) |-> ($past(state_q) == ST_ENTER || $past(state_q) == ST_SLEEP));

  // R5: normal after recovery only once two recovery cycles have elapsed
  recover_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_RECOVER && state_q == ST_NORMAL) |-> ($past(state_q, 2) == ST_RECOVER));

  // R4: a dropped request leaves entry or sleep for recovery
  drop_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_ENTER || state_q == ST_SLEEP) && !req_sync) |=> (state_q == ST_RECOVER));
endmodule

// File: rtl/slp_gate.sv
module slp_gate
  import slp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  slp_state_e state,
  input  logic       oe_req,
  input  logic       strobe_p,
  input  logic       strobe_c,
  output logic       permit,
  output logic       strobe_p_ok,
  output logic       strobe_c_ok,
  output logic       drive_en,
  output logic       violation
);
  assign permit      = permits(state);
  assign strobe_p_ok = strobe_p & permit;
  assign strobe_c_ok = strobe_c & permit;
  assign drive_en    = oe_req & permit;
  assign violation   = (strobe_p | strobe_c) & ~permit;

  // R6: no strobe is passed outside normal operation
  strobe_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_NORMAL) |-> !(strobe_p_ok || strobe_c_ok));

  // R7: a flagged violation never coincides with a forwarded strobe
  err_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    violation |-> !(strobe_p_ok || strobe_c_ok));

  // R8: drivers stay off outside normal operation
  hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_NORMAL) |-> !drive_en);
endmodule

// File: rtl/slp_ctrl.sv
module slp_ctrl
  import slp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ENTRY_CYC   = 2,
  parameter int RECOV_CYC   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_req,
  input  logic       oe_req,
  input  logic       strobe_p,
  input  logic       strobe_c,
  output logic [1:0] sleep_state,
  output logic       asleep,
  output logic       strobe_permit,
  output logic       strobe_p_ok,
  output logic       strobe_c_ok,
  output logic       data_drive_en,
  output logic       strobe_err
);
  logic       req_sync;
  slp_state_e state;
  logic       window_done;

  slp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(sleep_req), .sync_out(req_sync)
  );

  slp_fsm #(.ENTRY_CYC(ENTRY_CYC), .RECOV_CYC(RECOV_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_sync(req_sync),
    .state(state), .window_done(window_done)
  );

  slp_gate u_gate (
    .clk(clk), .rst_n(rst_n), .state(state), .oe_req(oe_req),
    .strobe_p(strobe_p), .strobe_c(strobe_c),
    .permit(strobe_permit), .strobe_p_ok(strobe_p_ok),
    .strobe_c_ok(strobe_c_ok), .drive_en(data_drive_en),
    .violation(strobe_err)
  );

  assign sleep_state = state;
  assign asleep      = (state == ST_SLEEP);

  // R1: permit and the sleep flag are never high together
  permit_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe_permit && asleep));

  // R3: the window counter has expired on entry into sleep
  entry_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(asleep)) |-> $past(window_done));
endmodule

// File: tb/tb_slp_ctrl.sv
module tb_slp_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b0, oe_req = 1'b0, strobe_p = 1'b0, strobe_c = 1'b0;
  logic [1:0] sleep_state;
  logic asleep, strobe_permit, strobe_p_ok, strobe_c_ok, data_drive_en, strobe_err;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  slp_ctrl dut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .oe_req(oe_req),
    .strobe_p(strobe_p), .strobe_c(strobe_c), .sleep_state(sleep_state),
    .asleep(asleep), .strobe_permit(strobe_permit), .strobe_p_ok(strobe_p_ok),
    .strobe_c_ok(strobe_c_ok), .data_drive_en(data_drive_en), .strobe_err(strobe_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // expected state after edge n for a request held W edges (R5 closed form)
  function automatic int exp_state(input int w, input int n);
    int r = w + 3;
    if (n < 3)           return 0;
    else if (n < r)      return (n <= 4) ? 1 : 2;
    else if (n < r + 2)  return 3;
    else                 return 0;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 state", sleep_state, 0);
    chk("R1 permit", strobe_permit, 1);
    chk("R1 err", strobe_err, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 state after release", sleep_state, 0);

    for (int w = 1; w <= 8; w++) begin
      repeat (4) @(negedge clk);
      sleep_req = 1'b1;
      for (int n = 1; n <= w + 8; n++) begin
        int es;
        logic sp, sc, oe, nrm;
        @(posedge clk);
        @(negedge clk);
        if (n >= w) sleep_req = 1'b0;
        sp = n[0]; sc = n[1]; oe = ~n[2];
        strobe_p = sp; strobe_c = sc; oe_req = oe;
        #1;
        es  = exp_state(w, n);
        nrm = (es == 0);
        if (es == 1) chk("R2 R4 state", sleep_state, es);
        else if (es == 2) chk("R3 state", sleep_state, es);
        else chk("R5 state", sleep_state, es);
        chk("R3 asleep", asleep, (es == 2) ? 1 : 0);
        chk("R6 permit", strobe_permit, nrm);
        chk("R6 strobe_p_ok", strobe_p_ok, sp & nrm);
        chk("R6 strobe_c_ok", strobe_c_ok, sc & nrm);
        chk("R7 err", strobe_err, (sp | sc) & ~nrm);
        chk("R8 drive", data_drive_en, oe & nrm);
      end
      strobe_p = 1'b0; strobe_c = 1'b0; oe_req = 1'b0;
    end

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule